// File: doc/BRIEF.md
# Adder Truth-Table Fitness Scorer

This unit grades one candidate configuration of a small feed-forward programmable logic array against the behaviour of a 2-bit adder. The candidate is presented as a flat configuration word. Each programmable node picks two sources and a logic function. Each array output picks one source. A single start pulse makes the unit walk through every combination of its four primary inputs, one combination per clock. In each step it compares the three array outputs with a built-in adder reference and counts the combinations where all three bits agree.

When the walk finishes, the unit raises a one-cycle completion pulse. The score stays visible until the next accepted start. A separate flag marks a candidate that matches every combination. A surrounding evolutionary engine loads a new candidate, pulses start, reads the score and stops its search when the flag rises. Selection, crossover and mutation live outside this unit.

Top module: `efe_fitness_eval`

## Requirements
- R1: An accepted sweep applies all 16 input combinations, one per clock cycle. Primary input 0 is the high bit and input 1 the low bit of operand A. Input 2 is the high bit and input 3 the low bit of operand B.
- R2: The reference result is the 3-bit value A + B, with bit 2 as the most significant bit. For example, A=2 with B=2 gives 100, and A=3 with B=3 gives 110. Array output k is compared with bit k of that value.
- R3: A combination adds one to the score only if all three array outputs equal the reference bits. After a sweep, fitness_o is the number of such combinations, from 0 to 16.
- R4: perfect_o is high exactly when the held score is 16. It is never high while busy_o is high.
- R5: start_i is accepted on a rising clock edge only while busy_o is low. busy_o is then high for 16 cycles. done_o is high for exactly one cycle, starting 16 edges after the accepting edge, and busy_o falls on that same edge.
- R6: A start_i pulse while busy_o is high has no effect. The running sweep keeps its timing and score, and no extra sweep or done_o pulse follows.
- R7: An accepted start clears the score to 0 on its accepting edge. Outside a sweep, fitness_o holds its value until the next accepted start.
- R8: Node j takes bits [13j+12:13j] of chrom_i as {function[2:0], source2[4:0], source1[4:0]}. Output k takes the 5-bit source index at bits [208+5k+4:208+5k].
- R9: Function codes: 0 = XOR, 1 = AND, 2 = OR, 3 = NOT of source1, 4 = source1 passed through. Codes 5, 6 and 7 also pass source1 through.
- R10: Source indices 0 to 3 are the primary inputs and 4 to 19 are nodes 0 to 15. A node that selects itself or a later node reads 0. An output index of 20 or more reads 0.
- R11: After reset, done_o, busy_o and perfect_o are low and fitness_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to score the present configuration |
| chrom_i | input | 223 | Candidate configuration, held stable during a sweep |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse when the score is final |
| fitness_o | output | 5 | Number of matching combinations |
| perfect_o | output | 1 | Score equals 16 |

## Verification
A corrupted vector counter or a wrong sweep-length compare shows up at the ports within the first sweep. done_o appears on the wrong cycle, or the score of the hand-built adder configuration differs from 16. A mis-decoded gene field, a wrong function code or a wrong source-range rule changes the score of one of the probe configurations as soon as that configuration completes. These probes include a broken carry node, out-of-range output selects, forward references, an inverter and a spare function code. Faults in start handling show up within one sweep: a restart that is not ignored shifts done_o or adds a second pulse, and a missing clear leaves a stale score.

// File: rtl/efe_pkg.sv
package efe_pkg;

  localparam int FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_XOR  = 3'd0,
    FN_AND  = 3'd1,
    FN_OR   = 3'd2,
    FN_INV  = 3'd3,
    FN_PASS = 3'd4
  } pe_fn_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_e;

  // Logic function of one programmable node; spare codes pass source1
  function automatic logic pe_eval(input logic [FN_W-1:0] fn,
                                   input logic x, input logic y);
    logic r;
    case (fn)
      FN_XOR:  r = x ^ y;
      FN_AND:  r = x & y;
      FN_OR:   r = x | y;
      FN_INV:  r = ~x;
      default: r = x;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/efe_array.sv
module efe_array
  import efe_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 3,
  parameter int NODES   = 16,
  localparam int SRC_N   = NUM_IN + NODES,
  localparam int SEL_W   = $clog2(SRC_N),
  localparam int GENE_W  = 2 * SEL_W + FN_W,
  localparam int CHROM_W = NODES * GENE_W + NUM_OUT * SEL_W
) (
  input  logic [CHROM_W-1:0] chrom_i,
  input  logic [NUM_IN-1:0]  in_i,
  output logic [NUM_OUT-1:0] out_o
);

  logic [SEL_W-1:0] sel1 [NODES];
  logic [SEL_W-1:0] sel2 [NODES];
  logic [FN_W-1:0]  fn   [NODES];
  logic [SEL_W-1:0] osel [NUM_OUT];

  // Gene unpacking: {function, source2, source1} per node, then output selects
  for (genvar j = 0; j < NODES; j++) begin : g_gene
    assign sel1[j] = chrom_i[j*GENE_W +: SEL_W];
    assign sel2[j] = chrom_i[j*GENE_W + SEL_W +: SEL_W];
    assign fn[j]   = chrom_i[j*GENE_W + 2*SEL_W +: FN_W];
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_osel
    assign osel[k] = chrom_i[NODES*GENE_W + k*SEL_W +: SEL_W];
  end

  // Node values are evaluated in index order inside one process, so a node
  // can only see sources below its own index (feed-forward by construction).
  logic [SRC_N-1:0] val;

  always_comb begin
    logic x;
    logic y;
    val = '0;
    val[NUM_IN-1:0] = in_i;
    for (int j = 0; j < NODES; j++) begin
      x = 1'b0;
      y = 1'b0;
      for (int s = 0; s < NUM_IN + j; s++) begin
        if (sel1[j] == SEL_W'(s)) x = val[s];
        if (sel2[j] == SEL_W'(s)) y = val[s];
      end
      val[NUM_IN + j] = pe_eval(fn[j], x, y);
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    always_comb begin
      out_o[k] = 1'b0;
      for (int s = 0; s < SRC_N; s++) begin
        if (osel[k] == SEL_W'(s)) out_o[k] = val[s];
      end
    end
  end

endmodule

// File: rtl/efe_ref.sv
module efe_ref #(
  parameter int OPW = 2,
  localparam int NUM_IN  = 2 * OPW,
  localparam int NUM_OUT = OPW + 1
) (
  input  logic [NUM_IN-1:0]  vec_i,
  output logic [NUM_OUT-1:0] sum_o
);

  logic [OPW-1:0] opa;
  logic [OPW-1:0] opb;

  // Operand A occupies the upper half of the vector, B the lower half
  assign opa   = vec_i[NUM_IN-1:OPW];
  assign opb   = vec_i[OPW-1:0];
  assign sum_o = {1'b0, opa} + {1'b0, opb};

endmodule

// File: rtl/efe_seq.sv
module efe_seq
  import efe_pkg::*;
#(
  parameter int VEC_W = 4,
  localparam int N_VEC = 1 << VEC_W,
  localparam int CNT_W = $clog2(N_VEC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             match_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] score_o
);

  localparam logic [VEC_W-1:0] LAST_VEC = VEC_W'(N_VEC - 1);

  sq_state_e        state_q, state_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [CNT_W-1:0] score_q, score_d;
  logic             done_q, done_d;
  logic             vec_en, score_en;

  always_comb begin
    state_d  = state_q;
    vec_d    = vec_q;
    score_d  = score_q;
    done_d   = 1'b0;
    vec_en   = 1'b0;
    score_en = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          state_d  = SQ_RUN;
          vec_d    = '0;
          score_d  = '0;
          vec_en   = 1'b1;
          score_en = 1'b1;
        end
      end
      SQ_RUN: begin
        if (match_i) begin
          score_d  = score_q + CNT_W'(1);
          score_en = 1'b1;
        end
        if (vec_q == LAST_VEC) begin
          state_d = SQ_IDLE;
          done_d  = 1'b1;
        end else begin
          vec_d  = vec_q + VEC_W'(1);
          vec_en = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      vec_q   <= '0;
      score_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (vec_en)   vec_q   <= vec_d;
      if (score_en) score_q <= score_d;
    end
  end

  assign vec_o   = vec_q;
  assign busy_o  = (state_q == SQ_RUN);
  assign done_o  = done_q;
  assign score_o = score_q;

  // R5: the final comparison ends the sweep and raises the pulse
  a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN && vec_q == LAST_VEC) |=> (done_q && state_q == SQ_IDLE));

  // R5: completion lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: mid-sweep the walk advances by one regardless of start_i
  a_r6_walk_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN && vec_q != LAST_VEC) |=>
      (state_q == SQ_RUN && vec_q == $past(vec_q) + VEC_W'(1)));

  // R3: the score grows by at most one per combination
  a_r3_score_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RUN) |=>
      (score_q == $past(score_q) || score_q == $past(score_q) + CNT_W'(1)));

  // R7: an idle unit without a start keeps its score
  a_r7_score_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && !start_i) |=> $stable(score_q));

  // R7: an accepted start clears the score
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && start_i) |=> (score_q == '0 && vec_q == '0));

endmodule

// File: rtl/efe_fitness_eval.sv
module efe_fitness_eval
  import efe_pkg::*;
#(
  parameter int OPW   = 2,
  parameter int NODES = 16,
  localparam int NUM_IN  = 2 * OPW,
  localparam int NUM_OUT = OPW + 1,
  localparam int SRC_N   = NUM_IN + NODES,
  localparam int SEL_W   = $clog2(SRC_N),
  localparam int GENE_W  = 2 * SEL_W + FN_W,
  localparam int CHROM_W = NODES * GENE_W + NUM_OUT * SEL_W,
  localparam int N_VEC   = 1 << NUM_IN,
  localparam int CNT_W   = $clog2(N_VEC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CHROM_W-1:0] chrom_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   fitness_o,
  output logic               perfect_o
);

  logic [NUM_IN-1:0]  vec;
  logic [NUM_IN-1:0]  arr_in;
  logic [NUM_OUT-1:0] arr_out;
  logic [NUM_OUT-1:0] ref_out;
  logic               match;
  logic [CNT_W-1:0]   score;

  // Primary input i takes vector bit NUM_IN-1-i (input 0 is A's top bit)
  for (genvar i = 0; i < NUM_IN; i++) begin : g_inmap
    assign arr_in[i] = vec[NUM_IN-1-i];
  end

  efe_array #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .NODES   (NODES)
  ) u_array (
    .chrom_i (chrom_i),
    .in_i    (arr_in),
    .out_o   (arr_out)
  );

  efe_ref #(
    .OPW (OPW)
  ) u_ref (
    .vec_i (vec),
    .sum_o (ref_out)
  );

  assign match = (arr_out == ref_out);

  efe_seq #(
    .VEC_W (NUM_IN)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .match_i (match),
    .vec_o   (vec),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .score_o (score)
  );

  assign fitness_o = score;
  assign perfect_o = (score == CNT_W'(N_VEC));

  // R4: a perfect score can only stand once the sweep is over
  a_r4_perfect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    perfect_o |-> !busy_o);

  // R3: the score never exceeds the number of combinations
  a_r3_score_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fitness_o <= CNT_W'(N_VEC));

endmodule

// File: tb/efe_fitness_eval_test.sv
module efe_fitness_eval_test;

  localparam int CLK_PERIOD = 10;
  localparam int NODES   = 16;
  localparam int SEL_W   = 5;
  localparam int GENE_W  = 13;
  localparam int CHROM_W = NODES * GENE_W + 3 * SEL_W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic [CHROM_W-1:0] chrom_i = '0;
  logic               busy_o, done_o, perfect_o;
  logic [4:0]         fitness_o;

  int n_chk  = 0;
  int n_fail = 0;
  int nc     = 0;

  int exp_q [$];
  int due_q [$];
  int dones = 0;

  efe_fitness_eval uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .chrom_i   (chrom_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .fitness_o (fitness_o),
    .perfect_o (perfect_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R8 gene layout helpers
  task automatic set_node(input int j, input int fn, input int s2, input int s1);
    chrom_i[j*GENE_W +: GENE_W] = {fn[2:0], s2[4:0], s1[4:0]};
  endtask

  task automatic set_outs(input int o0, input int o1, input int o2);
    chrom_i[NODES*GENE_W +: 3*SEL_W] = {o2[4:0], o1[4:0], o0[4:0]};
  endtask

  task automatic fill_pass();
    for (int j = 0; j < NODES; j++) set_node(j, 4, 0, 0);
  endtask

  // R1/R2 expected score when every output selects a primary input
  function automatic int direct_score(input int o0, input int o1, input int o2);
    int n = 0;
    for (int v = 0; v < 16; v++) begin
      logic [3:0] pin;
      logic [2:0] got, sum;
      for (int i = 0; i < 4; i++) pin[i] = v[3-i];
      sum = 3'(v[3:2]) + 3'(v[1:0]);
      got = {pin[o2], pin[o1], pin[o0]};
      if (got == sum) n++;
    end
    return n;
  endfunction

  // R2 hand-built ripple adder: outputs 0,1,2 are sum LSB, sum MSB, carry
  task automatic load_adder();
    fill_pass();
    set_node(0, 0, 3, 1);   // a1 ^ b1
    set_node(1, 1, 3, 1);   // a1 & b1
    set_node(2, 0, 2, 0);   // a0 ^ b0
    set_node(3, 0, 5, 6);   // t ^ c0
    set_node(4, 1, 2, 0);   // a0 & b0
    set_node(5, 1, 5, 6);   // t & c0
    set_node(6, 2, 9, 8);   // g | p
    set_outs(4, 7, 10);
  endtask

  // Driver: pushes the expected score and requests one sweep
  task automatic run_eval(input int exp_score);
    exp_q.push_back(exp_score);
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: predicts timing from accepted starts, compares completions
  logic prev_done = 1'b0;
  int   clr_at = -1;
  always @(negedge clk) begin
    nc++;
    if (rst_n) begin
      if (nc == clr_at) chk(fitness_o == 0 && busy_o, "R7 clear on start", fitness_o, 0);
      if (start_i && !busy_o) begin
        due_q.push_back(nc + 17);
        clr_at = nc + 1;
      end
      if (prev_done) chk(!done_o, "R5 single pulse", done_o, 0);
      if (done_o) begin
        dones++;
        if (exp_q.size() == 0 || due_q.size() == 0) begin
          chk(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          int e, d;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          chk(nc == d, "R5 done timing", nc, d);
          chk(!busy_o, "R5 busy low at done", busy_o, 0);
          chk(fitness_o == e, "R3 score", fitness_o, e);
          chk(perfect_o == (e == 16), "R4 perfect flag", perfect_o, (e == 16));
        end
      end
    end
    prev_done = done_o;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(fitness_o == 0, "R11 fitness", fitness_o, 0);
    chk(!done_o && !busy_o, "R11 done/busy", {done_o, busy_o}, 0);
    chk(!perfect_o, "R11 perfect", perfect_o, 0);

    // R2 R3 R4: correct adder scores 16
    load_adder();
    run_eval(16);

    // R7: score held while idle
    held = fitness_o;
    repeat (5) @(negedge clk);
    chk(fitness_o == held && perfect_o, "R7 hold", fitness_o, held);

    // R9 R1: all nodes pass-through, outputs pick inputs a1, b1, a0
    fill_pass();
    set_outs(1, 3, 0);
    run_eval(direct_score(1, 3, 0));

    // R9: OR replaced by AND on the carry node, carry stuck at 0 -> 10
    load_adder();
    set_node(6, 1, 9, 8);
    run_eval(10);

    // R10: out-of-range output selects read 0 -> only row 0 matches
    fill_pass();
    set_outs(31, 20, 25);
    run_eval(1);

    // R10: node 0 reading itself and a later node reads 0
    fill_pass();
    set_node(0, 2, 5, 4);
    set_outs(4, 4, 4);
    run_eval(1);

    // R9: inverter on a0 feeding all outputs never matches -> 0
    fill_pass();
    set_node(0, 3, 0, 0);
    set_outs(4, 4, 4);
    run_eval(0);

    // R9: spare code 6 passes source1 (a1)
    fill_pass();
    set_node(0, 6, 2, 1);
    set_outs(4, 3, 0);
    run_eval(direct_score(1, 3, 0));

    // R6: a second start during the sweep is ignored
    load_adder();
    exp_q.push_back(16);
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    repeat (6) @(posedge clk);
    #1 start_i = 1'b1;
    chk(busy_o, "R6 busy during restart", busy_o, 1);
    @(posedge clk); #1 start_i = 1'b0;
    held = dones;
    while (!done_o) @(negedge clk);
    repeat (25) @(negedge clk);
    chk(dones == held + 1 && !busy_o, "R6 no extra sweep", dones, held + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule